// File: doc/BRIEF.md
# Prioritized Overlay Alpha Compositor

This block merges one background pixel stream with up to eight rectangular overlay planes. Each pixel arrives with its output-image coordinate. The block checks that coordinate against the rectangle of every enabled overlay. Among the overlays that cover the pixel, it picks the one with the highest priority as the visible plane. It then blends that overlay's colour over the background with an 8-bit alpha. The alpha is either a fixed opacity for the whole plane or a value that comes with each pixel.

The block also tells the surrounding fetch logic which single overlay is visible at the current position, so that memory traffic is spent only on that plane. The overlay colour and per-pixel alpha for the current position come in on the same cycle as the coordinate. Configuration is static while pixels stream.

Top module: `ovl_compositor`

## Requirements
- R1: Overlay k covers pixel (x, y) when x0 <= x < x0 + w and y0 <= y < y0 + h. A rectangle with zero width or zero height covers nothing.
- R2: An overlay whose enable bit is 0 never covers any pixel, whatever its rectangle.
- R3: When several overlays cover a pixel, the one with the largest priority value is visible. On equal priority, the higher overlay index is visible.
- R4: One cycle after a valid pixel, `fetch_valid` is 1 and `fetch_idx` gives the visible overlay's index if any overlay covers the pixel. Otherwise `fetch_valid` is 0.
- R5: Each 8-bit channel (red in bits 23:16, green in 15:8, blue in 7:0) is blended as (a*ov + (255-a)*bg + 128) >> 8.
- R6: The alpha is the overlay's per-pixel alpha only when both its per-pixel select bit and its RGB-source bit are 1. In every other case it is the overlay's global opacity.
- R7: When no overlay covers a pixel, `out_rgb` equals the background pixel exactly.
- R8: `out_valid` equals `in_valid` delayed by exactly two clock cycles, and `out_rgb` belongs to the pixel given two cycles earlier.
- R9: While reset is held, `out_valid` and `fetch_valid` are 0.
- R10: Only the visible overlay affects the result. An overlay below an opaque visible overlay (global opacity 255) does not change `out_rgb` and is not reported for fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel present on inputs |
| in_x | input | CW | Output-image column |
| in_y | input | CW | Output-image row |
| bg_rgb | input | 24 | Background pixel, RGB888 |
| ovl_en | input | N_OVL | Enable bit per overlay |
| ovl_x0 | input | N_OVL*CW | Left edge per overlay |
| ovl_y0 | input | N_OVL*CW | Top edge per overlay |
| ovl_w | input | N_OVL*CW | Width per overlay |
| ovl_h | input | N_OVL*CW | Height per overlay |
| ovl_prio | input | N_OVL*PW | Priority per overlay, larger wins |
| ovl_glob_a | input | N_OVL*8 | Global opacity per overlay |
| ovl_use_pix | input | N_OVL | Per-pixel alpha select |
| ovl_is_rgb | input | N_OVL | Overlay source is RGB |
| ovl_rgb | input | N_OVL*24 | Overlay colour at current position |
| ovl_pix_a | input | N_OVL*8 | Overlay per-pixel alpha at current position |
| fetch_valid | output | 1 | A visible overlay exists for the previous pixel |
| fetch_idx | output | IW | Index of that visible overlay |
| out_valid | output | 1 | Composited pixel valid |
| out_rgb | output | 24 | Composited pixel |

## Verification
The assertions assume that the overlay configuration stays constant while pixels are in flight. They also assume that the background value is held only together with a valid pixel, so that the pass-through and fetch-source checks compare against the right beat. The stimulus changes the enable, rectangle, priority and alpha settings only after the pipeline has been idle for several cycles. It uses small coordinates, so that x0 + w never wraps the coordinate width.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef logic [23:0] rgb_t;
  typedef logic [7:0]  alpha_t;
  localparam int unsigned CH_BITS = 8;
  localparam int unsigned CH_NUM  = 3;
endpackage

// File: rtl/ovl_cover.sv
module ovl_cover #(
  parameter int unsigned CW = 12
) (
  input  logic          en,
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] y,
  input  logic [CW-1:0] x0,
  input  logic [CW-1:0] y0,
  input  logic [CW-1:0] w,
  input  logic [CW-1:0] h,
  output logic          hit
);
  logic [CW:0] x_end, y_end;
  logic        in_x, in_y;

  always_comb begin
    x_end = {1'b0, x0} + {1'b0, w};
    y_end = {1'b0, y0} + {1'b0, h};
    in_x  = (x >= x0) && ({1'b0, x} < x_end);
    in_y  = (y >= y0) && ({1'b0, y} < y_end);
    hit   = en && in_x && in_y;
  end
endmodule

// File: rtl/ovl_pick.sv
module ovl_pick #(
  parameter int unsigned N_OVL = 8,
  parameter int unsigned PW    = 3,
  localparam int unsigned IW   = (N_OVL > 1) ? $clog2(N_OVL) : 1
) (
  input  logic [N_OVL-1:0]    hit,
  input  logic [N_OVL*PW-1:0] prio,
  output logic                found,
  output logic [IW-1:0]       idx
);
  logic [PW-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N_OVL; i++) begin
      if (hit[i] && (!found || prio[i*PW +: PW] >= best)) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/ovl_mix.sv
module ovl_mix
  import ovl_pkg::*;
(
  input  alpha_t a,
  input  rgb_t   ov,
  input  rgb_t   bg,
  output rgb_t   mix
);
  for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
    logic [15:0] acc;
    always_comb begin
      acc = 16'(a) * 16'(ov[c*CH_BITS +: CH_BITS])
          + 16'(8'd255 - a) * 16'(bg[c*CH_BITS +: CH_BITS])
          + 16'd128;
      mix[c*CH_BITS +: CH_BITS] = 8'(acc >> 8);
    end
  end
endmodule

// File: rtl/ovl_compositor.sv
module ovl_compositor
  import ovl_pkg::*;
#(
  parameter int unsigned N_OVL = 8,
  parameter int unsigned CW    = 12,
  parameter int unsigned PW    = 3,
  localparam int unsigned IW   = (N_OVL > 1) ? $clog2(N_OVL) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [CW-1:0]       in_x,
  input  logic [CW-1:0]       in_y,
  input  logic [23:0]         bg_rgb,
  input  logic [N_OVL-1:0]    ovl_en,
  input  logic [N_OVL*CW-1:0] ovl_x0,
  input  logic [N_OVL*CW-1:0] ovl_y0,
  input  logic [N_OVL*CW-1:0] ovl_w,
  input  logic [N_OVL*CW-1:0] ovl_h,
  input  logic [N_OVL*PW-1:0] ovl_prio,
  input  logic [N_OVL*8-1:0]  ovl_glob_a,
  input  logic [N_OVL-1:0]    ovl_use_pix,
  input  logic [N_OVL-1:0]    ovl_is_rgb,
  input  logic [N_OVL*24-1:0] ovl_rgb,
  input  logic [N_OVL*8-1:0]  ovl_pix_a,
  output logic                fetch_valid,
  output logic [IW-1:0]       fetch_idx,
  output logic                out_valid,
  output logic [23:0]         out_rgb
);
  logic [N_OVL-1:0] hit;
  logic             found;
  logic [IW-1:0]    win;

  for (genvar k = 0; k < N_OVL; k++) begin : g_cov
    ovl_cover #(.CW(CW)) u_cov (
      .en (ovl_en[k]),
      .x  (in_x),
      .y  (in_y),
      .x0 (ovl_x0[k*CW +: CW]),
      .y0 (ovl_y0[k*CW +: CW]),
      .w  (ovl_w[k*CW +: CW]),
      .h  (ovl_h[k*CW +: CW]),
      .hit(hit[k])
    );
  end

  ovl_pick #(.N_OVL(N_OVL), .PW(PW)) u_pick (
    .hit  (hit),
    .prio (ovl_prio),
    .found(found),
    .idx  (win)
  );

  // stage 1: selection
  logic          s1_valid, s1_valid_d;
  logic          s1_hit, s1_hit_d;
  logic [IW-1:0] s1_idx, s1_idx_d;
  alpha_t        s1_a, s1_a_d;
  rgb_t          s1_ov, s1_ov_d;
  rgb_t          s1_bg, s1_bg_d;

  always_comb begin
    s1_valid_d = in_valid;
    s1_hit_d   = found;
    s1_idx_d   = win;
    s1_ov_d    = ovl_rgb[win*24 +: 24];
    s1_bg_d    = bg_rgb;
    if (ovl_use_pix[win] && ovl_is_rgb[win]) s1_a_d = ovl_pix_a[win*8 +: 8];
    else                                     s1_a_d = ovl_glob_a[win*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= s1_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_hit <= 1'b0;
      s1_idx <= '0;
      s1_a   <= '0;
      s1_ov  <= '0;
      s1_bg  <= '0;
    end else if (in_valid) begin
      s1_hit <= s1_hit_d;
      s1_idx <= s1_idx_d;
      s1_a   <= s1_a_d;
      s1_ov  <= s1_ov_d;
      s1_bg  <= s1_bg_d;
    end
  end

  assign fetch_valid = s1_valid && s1_hit;
  assign fetch_idx   = s1_idx;

  // stage 2: blend
  rgb_t mixed, s2_rgb_d, s2_rgb;
  logic s2_valid;

  ovl_mix u_mix (.a(s1_a), .ov(s1_ov), .bg(s1_bg), .mix(mixed));

  always_comb s2_rgb_d = s1_hit ? mixed : s1_bg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_valid <= 1'b0;
    else        s2_valid <= s1_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        s2_rgb <= '0;
    else if (s1_valid) s2_rgb <= s2_rgb_d;
  end

  assign out_valid = s2_valid;
  assign out_rgb   = s2_rgb;
endmodule

// File: rtl/ovl_compositor_chk.sv
module ovl_compositor_chk #(
  parameter int unsigned N_OVL = 8,
  localparam int unsigned IW   = (N_OVL > 1) ? $clog2(N_OVL) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [23:0]      bg_rgb,
  input logic [N_OVL-1:0] ovl_en,
  input logic             fetch_valid,
  input logic [IW-1:0]    fetch_idx,
  input logic             out_valid,
  input logic [23:0]      out_rgb
);
  assert_out_lat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 2));

  assert_fetch_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> ovl_en[fetch_idx]);

  assert_fetch_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> $past(in_valid));

  assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(fetch_valid)) |-> out_rgb == $past(bg_rgb, 2));

  always @(negedge clk)
    if (!rst_n) assert_rst_R9: assert (!out_valid && !fetch_valid);
endmodule

bind ovl_compositor ovl_compositor_chk #(.N_OVL(N_OVL)) u_chk (.*);

// File: tb/tb_ovl_compositor.sv
module tb_ovl_compositor;
  localparam int N = 8, CW = 12, PW = 3, IW = 3;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0;
  logic [CW-1:0] in_x = 0, in_y = 0;
  logic [23:0] bg_rgb = 0;
  logic [N-1:0] ovl_en, ovl_use_pix, ovl_is_rgb;
  logic [N*CW-1:0] ovl_x0, ovl_y0, ovl_w, ovl_h;
  logic [N*PW-1:0] ovl_prio;
  logic [N*8-1:0] ovl_glob_a, ovl_pix_a;
  logic [N*24-1:0] ovl_rgb;
  logic fetch_valid, out_valid;
  logic [IW-1:0] fetch_idx;
  logic [23:0] out_rgb;

  int ox0[N], oy0[N], ow[N], oh[N], opr[N], oga[N], opa[N];
  bit oen[N], oup[N], org[N];
  logic [23:0] orgb[N];

  always_comb
    for (int i = 0; i < N; i++) begin
      ovl_en[i] = oen[i]; ovl_use_pix[i] = oup[i]; ovl_is_rgb[i] = org[i];
      ovl_x0[i*CW +: CW] = CW'(ox0[i]); ovl_y0[i*CW +: CW] = CW'(oy0[i]);
      ovl_w[i*CW +: CW] = CW'(ow[i]);   ovl_h[i*CW +: CW] = CW'(oh[i]);
      ovl_prio[i*PW +: PW] = PW'(opr[i]);
      ovl_glob_a[i*8 +: 8] = 8'(oga[i]); ovl_pix_a[i*8 +: 8] = 8'(opa[i]);
      ovl_rgb[i*24 +: 24] = orgb[i];
    end

  ovl_compositor dut (.*);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  logic [23:0] q_rgb[$];
  bit q_fv[$];
  int q_fi[$];
  string q_tag[$], q_ftag[$];
  logic v1 = 0, v2 = 0;

  always @(posedge clk) begin
    v1 <= rst_n ? in_valid : 1'b0;
    v2 <= rst_n ? v1 : 1'b0;
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model(int x, int y, logic [23:0] bg,
                                output logic [23:0] o, output bit fv, output int fi);
    int best, a;
    fv = 0; fi = 0; best = 0;
    for (int i = 0; i < N; i++)
      if (oen[i] && x >= ox0[i] && x < ox0[i] + ow[i] && y >= oy0[i] && y < oy0[i] + oh[i])
        if (!fv || opr[i] >= best) begin fv = 1; fi = i; best = opr[i]; end
    if (!fv) o = bg;
    else begin
      a = (oup[fi] && org[fi]) ? opa[fi] : oga[fi];
      for (int c = 0; c < 3; c++)
        o[c*8 +: 8] = 8'((a * orgb[fi][c*8 +: 8] + (255 - a) * bg[c*8 +: 8] + 128) >> 8);
    end
  endfunction

  task automatic pix(int x, int y, logic [23:0] bg, string tag);
    logic [23:0] o; bit fv; int fi;
    model(x, y, bg, o, fv, fi);
    q_rgb.push_back(o); q_tag.push_back(tag);
    q_fv.push_back(fv); q_fi.push_back(fi); q_ftag.push_back(tag);
    in_x = CW'(x); in_y = CW'(y); bg_rgb = bg; in_valid = 1;
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic idle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < N; i++) begin
      oen[i] = 0; oup[i] = 0; org[i] = 0; ox0[i] = 0; oy0[i] = 0;
      ow[i] = 0; oh[i] = 0; opr[i] = 0; oga[i] = 0; opa[i] = 0; orgb[i] = 0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!out_valid && !fetch_valid, "R9 reset outputs", {out_valid, fetch_valid}, 0);
    end else if (!done) begin
      if (v1) begin
        bit fv; int fi; string t;
        fv = q_fv.pop_front(); fi = q_fi.pop_front(); t = q_ftag.pop_front();
        chk(fetch_valid == fv && (!fv || fetch_idx == fi), {t, " R4 fetch"},
            {fetch_valid, 4'(fetch_idx)}, {fv, 4'(fi)});
      end else if (fetch_valid)
        chk(0, "R4 spurious fetch", 1, 0);
      if (out_valid !== v2) chk(0, "R8 out_valid timing", out_valid, v2);
      if (v2) begin
        logic [23:0] e; string t;
        e = q_rgb.pop_front(); t = q_tag.pop_front();
        chk(out_rgb === e, t, out_rgb, e);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_cfg();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle();
    // R2, R7: disabled overlay covering everything
    ox0[0] = 0; oy0[0] = 0; ow[0] = 100; oh[0] = 100; oga[0] = 255; orgb[0] = 24'hFFFFFF;
    pix(5, 5, 24'h123456, "R2 R7 disabled");
    pix(99, 0, 24'hABCDEF, "R2 R7 disabled");
    idle();
    // R1, R5 edges with global alpha 128
    clear_cfg();
    oen[0] = 1; ox0[0] = 10; oy0[0] = 20; ow[0] = 4; oh[0] = 3; oga[0] = 128; orgb[0] = 24'hFF8000;
    pix(10, 20, 24'h204060, "R1 R5 top-left");
    pix(13, 22, 24'h204060, "R1 R5 bottom-right");
    pix(14, 20, 24'h204060, "R1 R7 right outside");
    pix(10, 23, 24'h204060, "R1 R7 below");
    pix(9, 21, 24'h000000, "R1 R7 left");
    pix(12, 21, 24'hFFFFFF, "R5 mid");
    idle();
    // R1 zero width overlay on top priority
    oen[1] = 1; ox0[1] = 10; oy0[1] = 20; ow[1] = 0; oh[1] = 3; opr[1] = 7; oga[1] = 255;
    pix(10, 20, 24'h010203, "R1 zero width");
    idle();
    // R3 priorities and ties
    clear_cfg();
    oen[2] = 1; ox0[2] = 0; oy0[2] = 0; ow[2] = 50; oh[2] = 50; opr[2] = 3; oga[2] = 200; orgb[2] = 24'h00FF00;
    oen[5] = 1; ox0[5] = 0; oy0[5] = 0; ow[5] = 50; oh[5] = 50; opr[5] = 3; oga[5] = 60;  orgb[5] = 24'h0000FF;
    oen[4] = 1; ox0[4] = 5; oy0[4] = 5; ow[4] = 5;  oh[4] = 5;  opr[4] = 5; oga[4] = 90;  orgb[4] = 24'hFF0000;
    pix(6, 6, 24'h808080, "R3 higher prio");
    pix(20, 20, 24'h808080, "R3 tie higher index");
    pix(9, 9, 24'h102030, "R3 higher prio edge");
    pix(60, 60, 24'h445566, "R4 R7 none");
    idle();
    // R6 per-pixel alpha
    clear_cfg();
    oen[6] = 1; ox0[6] = 0; oy0[6] = 0; ow[6] = 8; oh[6] = 8; oga[6] = 255; opa[6] = 64;
    oup[6] = 1; org[6] = 1; orgb[6] = 24'hC0FF10;
    pix(3, 3, 24'h3050A0, "R6 per-pixel alpha");
    idle();
    org[6] = 0;
    pix(3, 3, 24'h3050A0, "R6 non-rgb uses global");
    idle();
    oup[6] = 0; org[6] = 1;
    pix(4, 4, 24'h3050A0, "R6 select off uses global");
    idle();
    // R10 opaque top hides lower
    clear_cfg();
    oen[2] = 1; ox0[2] = 0; oy0[2] = 0; ow[2] = 40; oh[2] = 40; opr[2] = 2; oga[2] = 100; orgb[2] = 24'h00FF00;
    oen[7] = 1; ox0[7] = 10; oy0[7] = 10; ow[7] = 10; oh[7] = 10; opr[7] = 6; oga[7] = 255; orgb[7] = 24'h5A5A5A;
    pix(12, 12, 24'hFFFFFF, "R10 opaque top");
    pix(30, 30, 24'hFFFFFF, "R10 lower visible");
    pix(15, 15, 24'h000000, "R10 opaque top");
    idle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule